// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a clocked request port and an external asynchronous static RAM. The RAM has a 19-bit word address and a shared 8-bit data bus. A requester presents a read or a write with a valid/ready handshake. The controller then drives the memory's active-low select, write strobe and read-enable lines, along with the address. It handles the shared data pins as three separate signals: outgoing data, a drive enable, and incoming data.

The memory has no clock, so the controller stretches each access over whole system clock cycles until every minimum interval the memory needs is covered. Each phase length is worked out at elaboration time from a clock-period parameter and a set of nanosecond-scale timing parameters, in picoseconds.

- When idle, the memory is held in standby and the data pins are released.
- During a write the read enable stays high, so the memory never drives the bus.
- After every read, a turnaround phase lets the memory's outputs go to high impedance before the controller may drive the bus again.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever no access is in progress, mem_sel_n=1, mem_wstb_n=1, mem_rden_n=1, mem_dq_drive=0 and req_ready=1.
- R2: An accepted read (req_write=0) holds mem_sel_n=0, mem_rden_n=0 and mem_wstb_n=1 for exactly RD_CYC consecutive cycles, beginning the cycle after acceptance; mem_dq_drive stays 0 throughout.
- R3: rsp_valid is a one-cycle pulse in the cycle after the last read-wait cycle. In that cycle rsp_rdata equals the byte stored at the read address, captured from mem_dq_in on that same edge. A write never raises rsp_valid.
- R4: An accepted write (req_write=1) has the following shape:
  - mem_sel_n=0 and mem_rden_n=1 throughout.
  - One setup cycle with mem_wstb_n=1.
  - Exactly WP_CYC cycles with mem_wstb_n=0.
  - At least one hold cycle with mem_wstb_n=1.
  - The strobe pulse width, data setup, select-to-end and address-to-end intervals are all met.
- R5: mem_dq_drive is 1 with mem_dq_out equal to the accepted write data from the setup cycle through the hold cycle. mem_wstb_n is never 0 while mem_dq_drive is 0, and the strobe rises one cycle before drive is released.
- R6: mem_addr, and mem_dq_out while driven, stay constant from acceptance until the access ends.
- R7: After a read, there are TA_CYC turnaround cycles with mem_sel_n=1, mem_dq_drive=0 and req_ready=0. mem_dq_drive is never 1 while mem_rden_n=0 or within the memory's 7 ns output-disable time after it.
- R8: req_ready falls at the acceptance edge and stays 0 until the access ends. A request raised while req_ready=0 is ignored and changes no memory location.
- R9: Each phase length is max(1, ceil(t/CLK_PS)):
  - The read wait covers the cycle time, the address access time and the read-enable access time.
  - The strobe covers pulse width and data setup, plus select-to-end and address-to-end less the setup cycle.
  - The hold pads the write to the write cycle time.
  - The turnaround covers output disable.
  - At 10 ns these give read 2, strobe 1, hold 1 and turnaround 1, so both a read and a write keep req_ready low for 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 19 | Address to memory |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_wstb_n | output | 1 | Active-low write strobe |
| mem_rden_n | output | 1 | Active-low memory output enable |
| mem_dq_out | output | 8 | Data toward memory pins |
| mem_dq_drive | output | 1 | Enable for the data pin drivers |
| mem_dq_in | input | 8 | Data from memory pins |

## Verification
The bench runs reads and writes back to back in every order against a timing-checking memory model.

- **Short read wait.** A controller that samples read data early captures the model's filler byte instead of the stored byte.
- **Write straight after a read.** A missing or short turnaround shows up as bus contention.
- **Write timing.** A controller that releases the data together with the strobe, or cuts the strobe short, fails the model's write checks and stores a poison value.
- **Ignored requests.** Requests offered while the controller is busy, and the two end addresses of the array, show whether a stray write or an address slice leaks into memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_WAIT  = 3'd1,
    ST_RD_TURN  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5
  } ctl_state_e;

  // whole clock cycles needed to cover t_ps, never fewer than one
  function automatic int unsigned cycles_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    return max2(max2(a, b), c);
  endfunction

  // a - b clamped at zero
  function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/sram_ctl_phase_cnt.sv
module sram_ctl_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int SU_CYC = 1,
  parameter int WP_CYC = 1,
  parameter int WH_CYC = 1,
  parameter int TA_CYC = 1,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             ph_done,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_val,
  output logic             req_ready,
  output logic             accept,
  output logic             rd_done,
  output logic             wr_end,
  output logic             sel_n,
  output logic             wstb_n,
  output logic             rden_n,
  output logic             dq_drive
);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WH_LD = CNT_W'(WH_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

  ctl_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ph_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
            ph_val  = SU_LD;
          end else begin
            state_d = ST_RD_WAIT;
            ph_val  = RD_LD;
          end
        end
      end
      ST_RD_WAIT: if (ph_done) begin
        state_d = ST_RD_TURN; ph_load = 1'b1; ph_val = TA_LD;
      end
      ST_RD_TURN: if (ph_done) state_d = ST_IDLE;
      ST_WR_SETUP: if (ph_done) begin
        state_d = ST_WR_PULSE; ph_load = 1'b1; ph_val = WP_LD;
      end
      ST_WR_PULSE: if (ph_done) begin
        state_d = ST_WR_HOLD; ph_load = 1'b1; ph_val = WH_LD;
      end
      ST_WR_HOLD: if (ph_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_done   = (state_q == ST_RD_WAIT) && ph_done;
  assign wr_end    = (state_q == ST_WR_PULSE) && ph_done;

  // memory controls decoded from the state register only
  always_comb begin
    sel_n    = 1'b1;
    wstb_n   = 1'b1;
    rden_n   = 1'b1;
    dq_drive = 1'b0;
    unique case (state_q)
      ST_RD_WAIT:  begin sel_n = 1'b0; rden_n = 1'b0; end
      ST_WR_SETUP: begin sel_n = 1'b0; dq_drive = 1'b1; end
      ST_WR_PULSE: begin sel_n = 1'b0; wstb_n = 1'b0; dq_drive = 1'b1; end
      ST_WR_HOLD:  begin sel_n = 1'b0; dq_drive = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PS        = 10000,
  parameter int T_RD_CYC_PS   = 12000,
  parameter int T_ADDR_ACC_PS = 12000,
  parameter int T_RDEN_ACC_PS = 6000,
  parameter int T_WR_CYC_PS   = 12000,
  parameter int T_STB_PS      = 8000,
  parameter int T_DSU_PS      = 7000,
  parameter int T_SEL_END_PS  = 10000,
  parameter int T_ADR_END_PS  = 10000,
  parameter int T_OFF_PS      = 7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_wstb_n,
  output logic              mem_rden_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int SU_CYC = 1;
  localparam int RD_CYC = max3(cycles_ceil(T_RD_CYC_PS, CLK_PS),
                               cycles_ceil(T_ADDR_ACC_PS, CLK_PS),
                               cycles_ceil(T_RDEN_ACC_PS, CLK_PS));
  localparam int WP_CYC = max3(cycles_ceil(T_STB_PS, CLK_PS),
                               cycles_ceil(T_DSU_PS, CLK_PS),
                               sat_sub(max2(cycles_ceil(T_SEL_END_PS, CLK_PS),
                                            cycles_ceil(T_ADR_END_PS, CLK_PS)), SU_CYC));
  localparam int WH_CYC = max2(1, sat_sub(cycles_ceil(T_WR_CYC_PS, CLK_PS), SU_CYC + WP_CYC));
  localparam int TA_CYC = cycles_ceil(T_OFF_PS, CLK_PS);
  localparam int MAX_CYC = max3(max2(RD_CYC, SU_CYC), max2(WP_CYC, WH_CYC), TA_CYC);
  localparam int CNT_W  = $clog2(MAX_CYC) + 1;

  // named internal events
  logic             accept;
  logic             rd_done;
  logic             wr_end;
  logic             ph_done;
  logic             ph_load;
  logic [CNT_W-1:0] ph_val;

  sram_ctl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ph_load),
    .load_val(ph_val),
    .done    (ph_done)
  );

  sram_ctl_fsm #(
    .RD_CYC(RD_CYC), .SU_CYC(SU_CYC), .WP_CYC(WP_CYC),
    .WH_CYC(WH_CYC), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .ph_done  (ph_done),
    .ph_load  (ph_load),
    .ph_val   (ph_val),
    .req_ready(req_ready),
    .accept   (accept),
    .rd_done  (rd_done),
    .wr_end   (wr_end),
    .sel_n    (mem_sel_n),
    .wstb_n   (mem_wstb_n),
    .rden_n   (mem_rden_n),
    .dq_drive (mem_dq_drive)
  );

  sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_done  (rd_done),
    .dq_in    (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept,
  input logic              rd_done,
  input logic              wr_end,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_wstb_n,
  input logic              mem_rden_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_drive
);
  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && mem_wstb_n && mem_rden_n && !mem_dq_drive));

  assert_read_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rden_n |-> (!mem_sel_n && mem_wstb_n));

  assert_rsp_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rsp_valid);

  assert_rsp_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_write_encoding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wstb_n |-> (!mem_sel_n && mem_rden_n));

  assert_strobe_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wstb_n |-> mem_dq_drive);

  assert_data_held_past_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (mem_wstb_n && mem_dq_drive));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_drive && $past(mem_dq_drive)) |-> $stable(mem_dq_out));

  assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rden_n |-> !mem_dq_drive);

  assert_turn_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rden_n) |-> (mem_sel_n && !mem_dq_drive && !req_ready));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

bind sram_ctl sram_ctl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .accept      (accept),
  .rd_done     (rd_done),
  .wr_end      (wr_end),
  .rsp_valid   (rsp_valid),
  .mem_addr    (mem_addr),
  .mem_sel_n   (mem_sel_n),
  .mem_wstb_n  (mem_wstb_n),
  .mem_rden_n  (mem_rden_n),
  .mem_dq_out  (mem_dq_out),
  .mem_dq_drive(mem_dq_drive)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_sel_n, mem_wstb_n, mem_rden_n, mem_dq_drive;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int n_tests = 0;
  int n_fail  = 0;

  always #5ns clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wstb_n(mem_wstb_n),
    .mem_rden_n(mem_rden_n), .mem_dq_out(mem_dq_out),
    .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
  );

  // bench-side phase sizing in nanoseconds
  function automatic int need(input real t_ns);
    int n;
    n = int'($ceil(t_ns / 10.0));
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int bigger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  int exp_rd, exp_wp, exp_wh, exp_ta;
  initial begin
    exp_rd = bigger(need(12.0), bigger(need(12.0), need(6.0)));
    exp_wp = bigger(bigger(need(8.0), need(7.0)), bigger(need(10.0), need(10.0)) - 1);
    exp_wh = bigger(1, need(12.0) - 1 - exp_wp);
    exp_ta = need(7.0);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [7:0] mem_arr [logic [18:0]];
  logic [7:0] ref_mem [logic [18:0]];
  realtime t_addr = 0, t_rden = 0, t_sel = 0, t_stb = 0, t_dq = 0, t_off = -100ns;
  int wr_viol = 0;
  int contention = 0;

  always @(mem_addr) t_addr = $realtime;
  always @(negedge mem_rden_n) t_rden = $realtime;
  always @(negedge mem_sel_n) t_sel = $realtime;
  always @(negedge mem_wstb_n) t_stb = $realtime;
  always @(mem_dq_out or mem_dq_drive) t_dq = $realtime;

  always @(posedge mem_wstb_n) begin
    if (rst_n && !mem_sel_n) begin
      if (($realtime - t_stb < 8ns) || ($realtime - t_dq < 7ns) ||
          ($realtime - t_sel < 10ns) || ($realtime - t_addr < 10ns) ||
          !mem_dq_drive || !mem_rden_n) begin
        wr_viol++;
        mem_arr[mem_addr] = 8'hBB;
      end else begin
        mem_arr[mem_addr] = mem_dq_out;
      end
    end
  end

  initial begin
    #0.5ns;
    forever begin
      logic drv;
      drv = rst_n && !mem_sel_n && !mem_rden_n && mem_wstb_n;
      if (drv) begin
        t_off = $realtime;
        if (($realtime - t_addr >= 12ns) && ($realtime - t_rden >= 6ns) &&
            ($realtime - t_sel >= 12ns))
          mem_dq_in = mem_arr.exists(mem_addr) ? mem_arr[mem_addr] : 8'h00;
        else
          mem_dq_in = 8'hEE;
      end else begin
        mem_dq_in = 8'hEE;
      end
      if (rst_n && mem_dq_drive && (drv || ($realtime - t_off < 7ns))) contention++;
      #1ns;
    end
  end

  // ---------------- phase-length monitor ----------------
  int rd_run = 0, wp_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_rden_n) rd_run++;
      else if (rd_run > 0) begin check("R2 read phase length", rd_run, exp_rd); rd_run = 0; end
      if (!mem_wstb_n) wp_run++;
      else if (wp_run > 0) begin check("R9 strobe length", wp_run, exp_wp); wp_run = 0; end
    end
  end

  // ---------------- driver ----------------
  task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        input bit inject, input logic [18:0] ia, input logic [7:0] id);
    int n;
    int rsp_at;
    logic [7:0] got;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    n = 1; rsp_at = 0; got = '0;
    forever begin
      if (n == 1) begin
        check("R8 ready low after accept", req_ready, 1'b0);
        if (inject) begin
          req_valid = 1'b1; req_write = 1'b1; req_addr = ia; req_wdata = id;
        end else req_valid = 1'b0;
      end else req_valid = 1'b0;
      if (rsp_valid) begin
        rsp_at = n; got = rsp_rdata;
        check("R7 turnaround standby", {mem_sel_n, mem_dq_drive, req_ready}, 3'b100);
      end
      if (req_ready) break;
      n++;
      @(negedge clk);
    end
    if (wr) begin
      ref_mem[a] = d;
      check("R3 no response for write", rsp_at, 0);
      check("R9 write busy cycles", n, 1 + exp_wp + exp_wh + 1);
    end else begin
      check("R3 read latency", rsp_at, exp_rd + 1);
      check("R3 read data", got, ref_mem.exists(a) ? ref_mem[a] : 8'h00);
      check("R9 read busy cycles", n, exp_rd + exp_ta + 1);
    end
    check("R1 idle controls", {mem_sel_n, mem_wstb_n, mem_rden_n, mem_dq_drive}, 4'b1110);
  endtask

  initial begin
    logic [18:0] pool [16];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state",
          {req_ready, mem_sel_n, mem_wstb_n, mem_rden_n, mem_dq_drive, rsp_valid}, 6'b111100);

    // directed corners
    access(1'b0, 19'h12345, 8'h00, 1'b0, '0, '0);         // never written
    access(1'b1, 19'h7FFFF, 8'hA5, 1'b0, '0, '0);         // top address
    access(1'b0, 19'h7FFFF, 8'h00, 1'b0, '0, '0);         // write -> read back to back
    access(1'b1, 19'h00000, 8'h5A, 1'b0, '0, '0);         // read -> write back to back (R7)
    access(1'b0, 19'h00000, 8'h00, 1'b0, '0, '0);
    access(1'b1, 19'h00000, 8'hC3, 1'b1, 19'h00001, 8'h77); // busy request ignored (R8)
    access(1'b0, 19'h00001, 8'h00, 1'b0, '0, '0);
    access(1'b0, 19'h00000, 8'h00, 1'b1, 19'h00002, 8'h99); // ignored during read
    access(1'b0, 19'h00002, 8'h00, 1'b0, '0, '0);

    pool[0] = 19'h00000; pool[1] = 19'h7FFFF;
    for (int i = 2; i < 16; i++) pool[i] = 19'($urandom);
    for (int k = 0; k < 300; k++) begin
      access(1'($urandom_range(0, 1)), pool[$urandom_range(0, 15)], 8'($urandom),
             1'($urandom_range(0, 3) == 0), pool[$urandom_range(0, 15)], 8'($urandom));
    end

    repeat (3) @(negedge clk);
    check("R4 write timing violations", wr_viol, 0);
    check("R7 bus contention samples", contention, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule